// File: doc/BRIEF.md
# Virtual-to-physical translation and fault classifier

This block sits between the address generator and the translation lookaside buffer of a processor pipeline. It forms the virtual page number sent to the buffer from the incoming virtual address and takes the buffer's answer back: hit flag, page mask, and a pair of page entries (even and odd) with frame number, valid bit and dirty bit each. It picks the half of the pair that the address falls in and checks that half's permission bits. The result is either a physical address or a 3-bit fault code. With a fault it also gives the values that the exception logic loads into the address-translation registers.

Two kernel windows bypass the buffer and map straight onto the low physical space. The upper of the two is always uncached. Requests are single-cycle pulses. Each accepted request produces a registered response on the next clock. The buffer storage itself and exception vectoring live elsewhere.

Access type encoding: `2'b00` instruction fetch, `2'b10` data store, `2'b01` and `2'b11` data load. Fault codes: 0 none, 1 address error on fetch/load, 2 address error on store, 3 instruction refill, 4 data refill, 5 instruction invalid, 6 data invalid, 7 page modified.

Top module: `mmu_xlat`

## Requirements
- R1: `lookup_vpn` equals `vaddr[31:11]` in the same cycle. When `small_pages` is 0, its two low bits are forced to zero.
- R2: An address with `vaddr[31:29]==3'b100` bypasses the buffer with `paddr = vaddr[28:0]`. If `kernel_mode` is 0 or `misaligned` is 1, it faults with code 2 for a store and code 1 otherwise.
- R3: An address with `vaddr[31:29]==3'b101` bypasses the buffer with `paddr = vaddr[28:0]`. It never faults, whatever the mode or alignment.
- R4: Any other (mapped) address with `misaligned` set faults with code 2 for a store and code 1 otherwise, whatever the buffer returns.
- R5: An aligned mapped access with `tlb_hit` low faults with code 3 for a fetch and code 4 for a load or store.
- R6: On a hit, the page shift is 12 plus the number of set bits in `tlb_mask`. Virtual-address bit `[shift]` picks the even half (0) or the odd half (1). A clear valid bit in the picked half faults with code 5 for a fetch and code 6 for data.
- R7: A store to a valid picked half whose dirty bit is clear faults with code 7. Fetches and loads ignore the dirty bit.
- R8: For codes 3 to 7, `ehi_asid` equals `asid`, `ehi_vpn2` and `ctx_badvpn2` equal `lookup_vpn >> 2`, and `ehi_vpn2x` equals `lookup_vpn[1:0]`. For other codes these four are zero. `bad_vaddr` equals `vaddr` on any fault and is zero otherwise.
- R9: A successful mapped translation gives `paddr = ({pfn, 12'b0} with bits below shift cleared) | (vaddr bits below shift)`.
- R10: `uncached` is 1 exactly when the request did not fault and `vaddr[31]` and `vaddr[29]` are both 1.
- R11: Every cycle with `req_valid` high is answered by `rsp_valid` high on the next cycle, carrying that request's results. Without a request, `rsp_valid` is low and all result outputs hold their previous values. After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| vaddr | input | 32 | Virtual address |
| acc_type | input | 2 | 00 fetch, 10 store, 01/11 load |
| asid | input | 8 | Current address-space identifier |
| kernel_mode | input | 1 | Processor in kernel mode |
| misaligned | input | 1 | Access is misaligned |
| small_pages | input | 1 | Small-page lookup enabled |
| lookup_vpn | output | 21 | Page number presented to the buffer |
| tlb_hit | input | 1 | Buffer found a matching entry |
| tlb_mask | input | 16 | Page mask of the matching entry |
| tlb_pfn_even | input | 20 | Frame number, even half |
| tlb_pfn_odd | input | 20 | Frame number, odd half |
| tlb_valid_even | input | 1 | Valid bit, even half |
| tlb_valid_odd | input | 1 | Valid bit, odd half |
| tlb_dirty_even | input | 1 | Dirty (writable) bit, even half |
| tlb_dirty_odd | input | 1 | Dirty (writable) bit, odd half |
| rsp_valid | output | 1 | Response strobe |
| fault_valid | output | 1 | Response carries a fault |
| fault_code | output | 3 | Fault code |
| paddr | output | 32 | Physical address (zero on fault) |
| uncached | output | 1 | Access bypasses the caches |
| ehi_asid | output | 8 | Identifier for the translation-high register |
| ehi_vpn2 | output | 19 | Page-pair number for the translation-high register |
| ehi_vpn2x | output | 2 | Small-page extension bits |
| bad_vaddr | output | 32 | Faulting virtual address |
| ctx_badvpn2 | output | 19 | Page-pair number for the context register |

## Verification
`lookup_vpn` is combinational. The bench checks it one time step after it drives the inputs, in the same cycle. Every other output comes from a single register stage. The bench drives a request on a falling edge and compares the response on the next falling edge, which is one rising edge later. A behavioural model, called at drive time, gives the expected values. Idle cycles are checked against the values of the previous response to confirm that they hold.

// File: rtl/mmu_xlat_pkg.sv
package mmu_xlat_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_LOAD  = 2'b01,
    ACC_STORE = 2'b10,
    ACC_LOAD2 = 2'b11
  } acc_e;

  typedef enum logic [2:0] {
    FC_NONE     = 3'd0,
    FC_ADDR_RD  = 3'd1,
    FC_ADDR_WR  = 3'd2,
    FC_REFILL_I = 3'd3,
    FC_REFILL_D = 3'd4,
    FC_INVAL_I  = 3'd5,
    FC_INVAL_D  = 3'd6,
    FC_MODIFY   = 3'd7
  } fcode_e;

  function automatic logic is_tlb_fault(fcode_e c);
    return (c >= FC_REFILL_I);
  endfunction

endpackage

// File: rtl/mmu_seg_decode.sv
module mmu_seg_decode #(
  parameter int VA_W = 32,
  parameter int PA_W = 32
) (
  input  logic [VA_W-1:0] vaddr,
  output logic            in_win_cached,
  output logic            in_win_uncached,
  output logic [PA_W-1:0] direct_pa,
  output logic            uc_hint
);
  localparam int SEG_LSB = VA_W - 3;

  assign in_win_cached   = (vaddr[VA_W-1:SEG_LSB] == 3'b100);
  assign in_win_uncached = (vaddr[VA_W-1:SEG_LSB] == 3'b101);
  assign direct_pa       = PA_W'(vaddr[SEG_LSB-1:0]);
  assign uc_hint         = vaddr[VA_W-1] & vaddr[SEG_LSB];
endmodule

// File: rtl/mmu_page_pick.sv
module mmu_page_pick #(
  parameter int VA_W   = 32,
  parameter int PFN_W  = 20,
  parameter int MASK_W = 16,
  parameter int PA_W   = PFN_W + 12
) (
  input  logic [VA_W-1:0]   vaddr,
  input  logic [MASK_W-1:0] page_mask,
  input  logic [PFN_W-1:0]  pfn_even,
  input  logic [PFN_W-1:0]  pfn_odd,
  input  logic              v_even,
  input  logic              v_odd,
  input  logic              d_even,
  input  logic              d_odd,
  output logic              sel_valid,
  output logic              sel_dirty,
  output logic [PA_W-1:0]   page_pa
);
  localparam int CNT_W = $clog2(MASK_W + 1);
  localparam int SH_W  = $clog2(VA_W);

  logic [CNT_W-1:0] ones;
  logic [SH_W-1:0]  shift;
  logic             odd_half;
  logic [PA_W-1:0]  off_mask;
  logic [PA_W-1:0]  frame;
  logic [PA_W-1:0]  va_ext;

  always_comb begin
    ones = '0;
    for (int i = 0; i < MASK_W; i++) begin
      ones = ones + CNT_W'(page_mask[i]);
    end
  end

  assign shift    = SH_W'(ones) + SH_W'(12);
  assign odd_half = vaddr[shift];
  assign off_mask = ~({PA_W{1'b1}} << shift);
  assign frame    = {(odd_half ? pfn_odd : pfn_even), 12'b0};
  assign va_ext   = PA_W'(vaddr);

  assign sel_valid = odd_half ? v_odd : v_even;
  assign sel_dirty = odd_half ? d_odd : d_even;
  assign page_pa   = (frame & ~off_mask) | (va_ext & off_mask);
endmodule

// File: rtl/mmu_fault_classify.sv
module mmu_fault_classify
  import mmu_xlat_pkg::*;
(
  input  logic   win_cached,
  input  logic   win_uncached,
  input  logic   kernel_mode,
  input  logic   misaligned,
  input  acc_e   acc,
  input  logic   tlb_hit,
  input  logic   sel_valid,
  input  logic   sel_dirty,
  output fcode_e code
);
  logic is_fetch;
  logic is_store;

  assign is_fetch = (acc == ACC_FETCH);
  assign is_store = (acc == ACC_STORE);

  always_comb begin
    code = FC_NONE;
    if (win_cached) begin
      if (!kernel_mode || misaligned) code = is_store ? FC_ADDR_WR : FC_ADDR_RD;
    end else if (win_uncached) begin
      code = FC_NONE;
    end else if (misaligned) begin
      code = is_store ? FC_ADDR_WR : FC_ADDR_RD;
    end else if (!tlb_hit) begin
      code = is_fetch ? FC_REFILL_I : FC_REFILL_D;
    end else if (!sel_valid) begin
      code = is_fetch ? FC_INVAL_I : FC_INVAL_D;
    end else if (is_store && !sel_dirty) begin
      code = FC_MODIFY;
    end
  end
endmodule

// File: rtl/mmu_xlat.sv
module mmu_xlat
  import mmu_xlat_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int PFN_W  = 20,
  parameter int MASK_W = 16,
  parameter int ASID_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [VA_W-1:0]     vaddr,
  input  logic [1:0]          acc_type,
  input  logic [ASID_W-1:0]   asid,
  input  logic                kernel_mode,
  input  logic                misaligned,
  input  logic                small_pages,
  output logic [VA_W-12:0]    lookup_vpn,
  input  logic                tlb_hit,
  input  logic [MASK_W-1:0]   tlb_mask,
  input  logic [PFN_W-1:0]    tlb_pfn_even,
  input  logic [PFN_W-1:0]    tlb_pfn_odd,
  input  logic                tlb_valid_even,
  input  logic                tlb_valid_odd,
  input  logic                tlb_dirty_even,
  input  logic                tlb_dirty_odd,
  output logic                rsp_valid,
  output logic                fault_valid,
  output logic [2:0]          fault_code,
  output logic [PFN_W+11:0]   paddr,
  output logic                uncached,
  output logic [ASID_W-1:0]   ehi_asid,
  output logic [VA_W-14:0]    ehi_vpn2,
  output logic [1:0]          ehi_vpn2x,
  output logic [VA_W-1:0]     bad_vaddr,
  output logic [VA_W-14:0]    ctx_badvpn2
);
  localparam int VPN_W  = VA_W - 11;
  localparam int VPN2_W = VPN_W - 2;
  localparam int PA_W   = PFN_W + 12;

  logic              win_c, win_u, uc_hint;
  logic [PA_W-1:0]   direct_pa, page_pa;
  logic              sel_valid, sel_dirty;
  fcode_e            code;
  logic              tlb_f;

  logic              nx_fault, nx_unc;
  logic [PA_W-1:0]   nx_pa;
  logic [ASID_W-1:0] nx_asid;
  logic [VPN2_W-1:0] nx_vpn2;
  logic [1:0]        nx_vpn2x;
  logic [VA_W-1:0]   nx_bad;

  // page number toward the lookup array
  assign lookup_vpn = {vaddr[VA_W-1:13], vaddr[12:11] & {2{small_pages}}};

  mmu_seg_decode #(.VA_W(VA_W), .PA_W(PA_W)) u_seg (
    .vaddr(vaddr), .in_win_cached(win_c), .in_win_uncached(win_u),
    .direct_pa(direct_pa), .uc_hint(uc_hint)
  );

  mmu_page_pick #(.VA_W(VA_W), .PFN_W(PFN_W), .MASK_W(MASK_W), .PA_W(PA_W)) u_pick (
    .vaddr(vaddr), .page_mask(tlb_mask),
    .pfn_even(tlb_pfn_even), .pfn_odd(tlb_pfn_odd),
    .v_even(tlb_valid_even), .v_odd(tlb_valid_odd),
    .d_even(tlb_dirty_even), .d_odd(tlb_dirty_odd),
    .sel_valid(sel_valid), .sel_dirty(sel_dirty), .page_pa(page_pa)
  );

  mmu_fault_classify u_cls (
    .win_cached(win_c), .win_uncached(win_u), .kernel_mode(kernel_mode),
    .misaligned(misaligned), .acc(acc_e'(acc_type)), .tlb_hit(tlb_hit),
    .sel_valid(sel_valid), .sel_dirty(sel_dirty), .code(code)
  );

  // next-state
  always_comb begin
    tlb_f    = is_tlb_fault(code);
    nx_fault = (code != FC_NONE);
    nx_pa    = nx_fault ? '0 : ((win_c || win_u) ? direct_pa : page_pa);
    nx_unc   = !nx_fault && uc_hint;
    nx_asid  = tlb_f ? asid : '0;
    nx_vpn2  = tlb_f ? lookup_vpn[VPN_W-1:2] : '0;
    nx_vpn2x = tlb_f ? lookup_vpn[1:0] : 2'b00;
    nx_bad   = nx_fault ? vaddr : '0;
  end

  // registers, loaded only on a request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      fault_valid <= 1'b0;
      fault_code  <= 3'd0;
      paddr       <= '0;
      uncached    <= 1'b0;
      ehi_asid    <= '0;
      ehi_vpn2    <= '0;
      ehi_vpn2x   <= 2'b00;
      bad_vaddr   <= '0;
      ctx_badvpn2 <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        fault_valid <= nx_fault;
        fault_code  <= code;
        paddr       <= nx_pa;
        uncached    <= nx_unc;
        ehi_asid    <= nx_asid;
        ehi_vpn2    <= nx_vpn2;
        ehi_vpn2x   <= nx_vpn2x;
        bad_vaddr   <= nx_bad;
        ctx_badvpn2 <= nx_vpn2;
      end
    end
  end

  p_rsp_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_no_rsp_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && $stable(fault_code) && $stable(paddr));
  p_win_u_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && vaddr[VA_W-1:VA_W-3] == 3'b101 |=> !fault_valid && uncached);
  p_miss_refill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && vaddr[VA_W-1:VA_W-2] != 2'b10 && !misaligned && !tlb_hit
    |=> fault_valid && (fault_code == 3'd3 || fault_code == 3'd4));
  p_fetch_no_mod_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && acc_type == 2'b00 |=> fault_code != 3'd7);
  p_badva_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && vaddr[VA_W-1:VA_W-2] != 2'b10 && misaligned
    |=> fault_valid && bad_vaddr == $past(vaddr) && ehi_vpn2 == '0);
endmodule

// File: tb/mmu_xlat_tb.sv
module mmu_xlat_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] vaddr = '0;
  logic [1:0]  acc_type = '0;
  logic [7:0]  asid = '0;
  logic        kernel_mode = 1'b0, misaligned = 1'b0, small_pages = 1'b0;
  logic [20:0] lookup_vpn;
  logic        tlb_hit = 1'b0;
  logic [15:0] tlb_mask = '0;
  logic [19:0] tlb_pfn_even = '0, tlb_pfn_odd = '0;
  logic        tlb_valid_even = 1'b0, tlb_valid_odd = 1'b0;
  logic        tlb_dirty_even = 1'b0, tlb_dirty_odd = 1'b0;
  logic        rsp_valid, fault_valid, uncached;
  logic [2:0]  fault_code;
  logic [31:0] paddr, bad_vaddr;
  logic [7:0]  ehi_asid;
  logic [18:0] ehi_vpn2, ctx_badvpn2;
  logic [1:0]  ehi_vpn2x;

  int total = 0, bad = 0;
  bit done = 0;

  // expected response
  int          e_code;
  logic [31:0] e_pa, e_bad;
  logic        e_unc;
  logic [7:0]  e_asid;
  logic [18:0] e_vpn2;
  logic [1:0]  e_vpn2x;

  always #4 clk = ~clk;  // 125 MHz

  mmu_xlat u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .vaddr(vaddr),
    .acc_type(acc_type), .asid(asid), .kernel_mode(kernel_mode),
    .misaligned(misaligned), .small_pages(small_pages), .lookup_vpn(lookup_vpn),
    .tlb_hit(tlb_hit), .tlb_mask(tlb_mask), .tlb_pfn_even(tlb_pfn_even),
    .tlb_pfn_odd(tlb_pfn_odd), .tlb_valid_even(tlb_valid_even),
    .tlb_valid_odd(tlb_valid_odd), .tlb_dirty_even(tlb_dirty_even),
    .tlb_dirty_odd(tlb_dirty_odd), .rsp_valid(rsp_valid),
    .fault_valid(fault_valid), .fault_code(fault_code), .paddr(paddr),
    .uncached(uncached), .ehi_asid(ehi_asid), .ehi_vpn2(ehi_vpn2),
    .ehi_vpn2x(ehi_vpn2x), .bad_vaddr(bad_vaddr), .ctx_badvpn2(ctx_badvpn2)
  );

  task automatic chk(string req, string what, longint got, longint exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h (vaddr=%08h)", req, what, got, exp, vaddr);
    end
  endtask

  function automatic string tag_of(int c, logic [2:0] seg);
    case (c)
      1, 2:    return (seg == 3'b100) ? "R2" : "R4";
      3, 4:    return "R5";
      5, 6:    return "R6";
      7:       return "R7";
      default: return (seg == 3'b101) ? "R3" : (seg == 3'b100 ? "R2" : "R9");
    endcase
  endfunction

  // behavioural reference
  task automatic model();
    longint vpn, pfn, sh, pa;
    int ones;
    bit odd, v, d, st, fe;
    vpn = longint'(vaddr) >> 11;
    if (!small_pages) vpn = vpn & ~longint'(3);
    st = (acc_type == 2'b10);
    fe = (acc_type == 2'b00);
    e_code = 0;
    pa = 0;
    if (vaddr[31:29] == 3'b100) begin
      pa = longint'(vaddr) & 64'h1FFF_FFFF;
      if (!kernel_mode || misaligned) e_code = st ? 2 : 1;
    end else if (vaddr[31:29] == 3'b101) begin
      pa = longint'(vaddr) & 64'h1FFF_FFFF;
    end else if (misaligned) begin
      e_code = st ? 2 : 1;
    end else if (!tlb_hit) begin
      e_code = fe ? 3 : 4;
    end else begin
      ones = 0;
      for (int i = 0; i < 16; i++) if (tlb_mask[i]) ones++;
      sh = 12 + ones;
      odd = ((longint'(vaddr) >> sh) & 1) == 1;
      v   = odd ? tlb_valid_odd : tlb_valid_even;
      d   = odd ? tlb_dirty_odd : tlb_dirty_even;
      pfn = odd ? tlb_pfn_odd : tlb_pfn_even;
      if (!v) e_code = fe ? 5 : 6;
      else if (st && !d) e_code = 7;
      else pa = (((pfn << 12) >> sh) << sh) | (longint'(vaddr) & ((longint'(1) << sh) - 1));
    end
    e_pa    = pa[31:0];
    e_unc   = (e_code == 0) && vaddr[31] && vaddr[29];
    e_bad   = (e_code != 0) ? vaddr : 32'h0;
    e_asid  = (e_code >= 3) ? asid : 8'h0;
    e_vpn2  = (e_code >= 3) ? vpn[20:2] : 19'h0;
    e_vpn2x = (e_code >= 3) ? vpn[1:0] : 2'b00;
  endtask

  task automatic cmp_all(string r);
    chk(r, "code", fault_code, e_code);
    chk(r, "fault_valid", fault_valid, e_code != 0);
    if (e_code == 0) chk(r, "paddr", paddr, e_pa);
    chk("R10", "uncached", uncached, e_unc);
    chk("R8", "bad_vaddr", bad_vaddr, e_bad);
    chk("R8", "ehi_asid", ehi_asid, e_asid);
    chk("R8", "ehi_vpn2", ehi_vpn2, e_vpn2);
    chk("R8", "ehi_vpn2x", ehi_vpn2x, e_vpn2x);
    chk("R8", "ctx_badvpn2", ctx_badvpn2, e_vpn2);
  endtask

  // called on a falling edge; returns on the next falling edge
  task automatic issue();
    logic [20:0] ev;
    string r;
    req_valid = 1'b1;
    #1;
    ev = vaddr[31:11];
    if (!small_pages) ev[1:0] = 2'b00;
    chk("R1", "lookup_vpn", lookup_vpn, ev);
    model();
    r = tag_of(e_code, vaddr[31:29]);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11", "rsp_valid", rsp_valid, 1);
    cmp_all(r);
  endtask

  task automatic idle();
    req_valid = 1'b0;
    vaddr = $urandom; misaligned = $urandom; tlb_hit = $urandom;
    @(negedge clk);
    chk("R11", "rsp_valid idle", rsp_valid, 0);
    cmp_all("R11");
  endtask

  task automatic set_tlb(bit hit, logic [15:0] m, logic [19:0] pe, logic [19:0] po,
                         bit ve, bit vo, bit de, bit dd);
    tlb_hit = hit; tlb_mask = m; tlb_pfn_even = pe; tlb_pfn_odd = po;
    tlb_valid_even = ve; tlb_valid_odd = vo; tlb_dirty_even = de; tlb_dirty_odd = dd;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11", "reset rsp_valid", rsp_valid, 0);
    chk("R11", "reset code", fault_code, 0);
    chk("R11", "reset paddr", paddr, 0);
    chk("R11", "reset bad_vaddr", bad_vaddr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    asid = 8'h5A;

    // R2: cached window, kernel aligned / user / misaligned store
    vaddr = 32'h8012_3456; acc_type = 2'b01; kernel_mode = 1; misaligned = 0; issue();
    kernel_mode = 0; issue();
    kernel_mode = 1; misaligned = 1; acc_type = 2'b10; issue();
    // R3: uncached window, user mode, misaligned
    vaddr = 32'hA1B2_C3D4; kernel_mode = 0; misaligned = 1; issue();
    // R4: mapped misaligned store and fetch, TLB says hit
    set_tlb(1, 16'h0, 20'h11111, 20'h22222, 1, 1, 1, 1);
    vaddr = 32'h0040_1002; acc_type = 2'b10; issue();
    acc_type = 2'b00; issue();
    misaligned = 0;
    // R5: miss fetch / load, small pages on
    tlb_hit = 0; small_pages = 1; vaddr = 32'h7FFF_F800; acc_type = 2'b00; issue();
    acc_type = 2'b11; issue();
    small_pages = 0; issue();
    // R6: odd half invalid with mask 0x3 (shift 14)
    set_tlb(1, 16'h0003, 20'h12340, 20'h56780, 1, 0, 1, 1);
    vaddr = 32'h0000_4ABC; acc_type = 2'b01; issue();
    acc_type = 2'b00; issue();
    vaddr = 32'h0000_0ABC; acc_type = 2'b01; issue();  // even half, R9
    // R7: store to clean page, fetch and load same page
    set_tlb(1, 16'h0, 20'hABCDE, 20'h13579, 1, 1, 0, 0);
    vaddr = 32'h0001_0123; acc_type = 2'b10; issue();
    acc_type = 2'b00; issue();
    acc_type = 2'b01; issue();
    // R10: mapped region with uncached bits set (0xE...)
    set_tlb(1, 16'h00FF, 20'hFFF00, 20'h00100, 1, 1, 1, 1);
    vaddr = 32'hE012_3456; acc_type = 2'b10; issue();
    idle(); idle();

    for (int n = 0; n < 600; n++) begin
      vaddr = $urandom; acc_type = $urandom; asid = $urandom;
      kernel_mode = $urandom; misaligned = ($urandom % 4) == 0;
      small_pages = $urandom;
      set_tlb(($urandom % 5) != 0, 16'($urandom), 20'($urandom), 20'($urandom),
              $urandom, $urandom, $urandom, $urandom);
      if (n % 7 == 3) idle(); else issue();
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL R11 watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule